// File: doc/BRIEF.md
# Packed Byte Absolute-Difference Accumulator

This block is a motion-estimation helper. Each operation takes two 64-bit words, each holding eight unsigned 8-bit pixels. It forms the absolute difference of every pair of matching pixels, adds the eight differences together, and adds that total to a 16-bit running value supplied with the operation. A block-matching engine feeds one row of a candidate block and one row of the reference block per cycle. It passes the previous result back as the running value, so a full block cost builds up without any compare-and-branch sequence.

The datapath has three register stages and is fully pipelined, so a new operation may be issued on every clock. The first stage computes the eight absolute differences without branching, by subtracting both ways and choosing by the borrow. It then reduces them into two half sums. The second stage joins the halves into an 11-bit total. The third stage adds that total to the running value, modulo 2^16. Address generation, memory loads and search control belong to the surrounding engine.

Top module: `sad_accum_unit`

## Requirements
- R1: Pixel lane i of each operand occupies bits [8i+7:8i] and is an unsigned value 0..255. A difference confined to one lane contributes exactly that lane's absolute difference.
- R2: For every issued operation, `res_sum` equals (`acc_in` + sum over the eight lanes of |a_i - b_i|) modulo 2^16. Swapping the two operands gives the same result.
- R3: An operation sampled with `op_valid` high on rising edge t produces `res_valid` high, with its result on `res_sum`, right after rising edge t+2.
- R4: Operations may be issued on consecutive cycles. Each one yields its own result, in issue order, one per cycle.
- R5: A cycle with `op_valid` low yields `res_valid` low three edges later, and `res_sum` keeps the last result it held.
- R6: Identical operands produce a lane total of zero, so `res_sum` equals `acc_in`.
- R7: Operands of all 0x00 against all 0xFF, in either order, produce a lane total of 2040.
- R8: The 16-bit accumulation wraps: `acc_in` = 0xFFFF with a lane total of 2040 gives 2039.
- R9: While `rst` is high at a rising edge, `res_valid` and `res_sum` are cleared to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue strobe for one operation |
| pix_a | input | 64 | First operand, eight packed unsigned bytes |
| pix_b | input | 64 | Second operand, eight packed unsigned bytes |
| acc_in | input | 16 | Running value to add the lane total to |
| res_valid | output | 1 | Result strobe, three edges after issue |
| res_sum | output | 16 | Accumulated result |

## Verification
The tests use several input patterns. Equal operands show that the zero case passes `acc_in` through unchanged. All-zero against all-0xFF, in both orders, reaches the maximum total and shows that the borrow selection works both ways. A walk that changes a single lane at a time, with a different amount per lane, shows that every byte is placed and weighted correctly. Random operands issued back to back, and again with idle gaps, are compared against a bench model. This shows per-cycle ordering and the three-edge timing, and shows that the output holds its value in idle cycles. A running value near 0xFFFF shows the 16-bit wrap.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int DEF_LANES = 8;
  localparam int DEF_PIX_W = 8;
  localparam int DEF_ACC_W = 16;

  function automatic int part_width(input int lanes_in_group, input int pix_w);
    return pix_w + $clog2(lanes_in_group);
  endfunction
endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] d
);
  logic [W:0]   a_minus_b;
  logic [W-1:0] b_minus_a;

  always_comb begin
    a_minus_b = {1'b0, a} - {1'b0, b};
    b_minus_a = b - a;
    d = a_minus_b[W] ? b_minus_a : a_minus_b[W-1:0];
  end
endmodule

// File: rtl/sad_group_sum.sv
module sad_group_sum #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int OW = 10
) (
  input  logic [N*W-1:0] a,
  input  logic [N*W-1:0] b,
  output logic [OW-1:0]  sum
);
  logic [W-1:0] diff [N];

  for (genvar i = 0; i < N; i++) begin : g_lane
    sad_absdiff #(.W(W)) u_abs (
      .a(a[i*W +: W]),
      .b(b[i*W +: W]),
      .d(diff[i])
    );
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) sum = sum + OW'(diff[i]);
  end
endmodule

// File: rtl/sad_accum_unit.sv
module sad_accum_unit #(
  parameter int LANES = sad_pkg::DEF_LANES,
  parameter int PIX_W = sad_pkg::DEF_PIX_W,
  parameter int ACC_W = sad_pkg::DEF_ACC_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   op_valid,
  input  logic [LANES*PIX_W-1:0] pix_a,
  input  logic [LANES*PIX_W-1:0] pix_b,
  input  logic [ACC_W-1:0]       acc_in,
  output logic                   res_valid,
  output logic [ACC_W-1:0]       res_sum
);
  localparam int HALF   = LANES / 2;
  localparam int HALF_W = HALF * PIX_W;
  localparam int PART_W = sad_pkg::part_width(HALF, PIX_W);
  localparam int SUM_W  = PART_W + 1;

  logic [PART_W-1:0] part_c [2];

  for (genvar g = 0; g < 2; g++) begin : g_half
    sad_group_sum #(.N(HALF), .W(PIX_W), .OW(PART_W)) u_grp (
      .a(pix_a[g*HALF_W +: HALF_W]),
      .b(pix_b[g*HALF_W +: HALF_W]),
      .sum(part_c[g])
    );
  end

  // stage 1: half sums
  logic              s1_v;
  logic [PART_W-1:0] s1_lo, s1_hi;
  logic [ACC_W-1:0]  s1_acc;
  // stage 2: lane total
  logic              s2_v;
  logic [SUM_W-1:0]  s2_sum;
  logic [ACC_W-1:0]  s2_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= op_valid;
      s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    s1_lo  <= part_c[0];
    s1_hi  <= part_c[1];
    s1_acc <= acc_in;
    s2_sum <= SUM_W'(s1_lo) + SUM_W'(s1_hi);
    s2_acc <= s1_acc;
  end

  // stage 3: accumulate, registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_sum   <= '0;
    end else begin
      res_valid <= s2_v;
      if (s2_v) res_sum <= s2_acc + ACC_W'(s2_sum);
    end
  end
endmodule

// File: rtl/sad_accum_chk.sv
module sad_accum_chk #(
  parameter int LANES = 8,
  parameter int PIX_W = 8,
  parameter int ACC_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   op_valid,
  input logic [LANES*PIX_W-1:0] pix_a,
  input logic [LANES*PIX_W-1:0] pix_b,
  input logic [ACC_W-1:0]       acc_in,
  input logic                   res_valid,
  input logic [ACC_W-1:0]       res_sum
);
  localparam int MAX_TOT = LANES * ((1 << PIX_W) - 1);

  function automatic logic [ACC_W-1:0] model(input logic [LANES*PIX_W-1:0] x,
                                             input logic [LANES*PIX_W-1:0] y,
                                             input logic [ACC_W-1:0] acc);
    int t;
    t = 0;
    for (int i = 0; i < LANES; i++) begin
      if (x[i*PIX_W +: PIX_W] > y[i*PIX_W +: PIX_W])
        t = t + int'(x[i*PIX_W +: PIX_W]) - int'(y[i*PIX_W +: PIX_W]);
      else
        t = t + int'(y[i*PIX_W +: PIX_W]) - int'(x[i*PIX_W +: PIX_W]);
    end
    return acc + ACC_W'(t);
  endfunction

  logic             v_q [3];
  logic [ACC_W-1:0] e_q [3];
  logic [ACC_W-1:0] a_q [3];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) v_q[i] <= 1'b0;
    end else begin
      v_q[0] <= op_valid;
      v_q[1] <= v_q[0];
      v_q[2] <= v_q[1];
    end
    e_q[0] <= model(pix_a, pix_b, acc_in);
    e_q[1] <= e_q[0];
    e_q[2] <= e_q[1];
    a_q[0] <= acc_in;
    a_q[1] <= a_q[0];
    a_q[2] <= a_q[1];
  end

  // R3 / R4: result strobe follows issue by three edges
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    res_valid == v_q[2]);

  // R2: value matches the accumulated sum of absolute differences
  a_r2_value: assert property (@(posedge clk) disable iff (rst)
    (res_valid && v_q[2]) |-> res_sum == e_q[2]);

  // R7: lane total never exceeds the maximum
  a_r7_bounded: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (ACC_W'(res_sum - a_q[2]) <= ACC_W'(MAX_TOT)));

  // R5: output holds on idle result slots
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res_sum));

  // R9: reset clears the result strobe
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (!res_valid && res_sum == '0));
endmodule

bind sad_accum_unit sad_accum_chk #(
  .LANES(LANES), .PIX_W(PIX_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .pix_a(pix_a), .pix_b(pix_b),
  .acc_in(acc_in), .res_valid(res_valid), .res_sum(res_sum)
);

// File: tb/tb_sad_accum_unit.sv
module tb_sad_accum_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [63:0] pix_a = '0;
  logic [63:0] pix_b = '0;
  logic [15:0] acc_in = '0;
  logic        res_valid;
  logic [15:0] res_sum;

  int n_chk = 0;
  int n_bad = 0;

  // pipeline of expected results, index 2 = oldest
  logic        p_v   [3];
  logic [15:0] p_s   [3];
  string       p_tag [3];
  logic [15:0] last_sum;

  always #2.5 clk = ~clk;

  sad_accum_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .pix_a(pix_a), .pix_b(pix_b),
    .acc_in(acc_in), .res_valid(res_valid), .res_sum(res_sum)
  );

  function automatic logic [15:0] ref_sum(input logic [63:0] a, input logic [63:0] b,
                                          input logic [15:0] acc);
    int t;
    t = 0;
    for (int i = 0; i < 8; i++) begin
      int x, y;
      x = int'(a[i*8 +: 8]);
      y = int'(b[i*8 +: 8]);
      t += (x > y) ? x - y : y - x;
    end
    return 16'((int'(acc) + t) % 65536);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: check result due now, then drive a new operation
  task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                      input logic [15:0] acc, input string tag);
    @(negedge clk);
    check({p_tag[2], " (R3) strobe"}, 16'(res_valid), 16'(p_v[2]));
    if (p_v[2]) begin
      last_sum = p_s[2];
      check(p_tag[2], res_sum, p_s[2]);
    end else begin
      check("R5 hold", res_sum, last_sum);
    end
    p_v[2] = p_v[1]; p_s[2] = p_s[1]; p_tag[2] = p_tag[1];
    p_v[1] = p_v[0]; p_s[1] = p_s[0]; p_tag[1] = p_tag[0];
    p_v[0] = v; p_s[0] = ref_sum(a, b, acc); p_tag[0] = tag;
    op_valid = v; pix_a = a; pix_b = b; acc_in = acc;
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) step(1'b0, '0, '0, '0, "idle");
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin p_v[i] = 1'b0; p_s[i] = '0; p_tag[i] = "idle"; end
    last_sum = '0;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9 valid", 16'(res_valid), 16'd0);
    check("R9 sum", res_sum, 16'd0);
    rst = 1'b0;
  endtask

  task automatic t_equal();
    step(1'b1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 16'd1234, "R6 equal");
    step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0, "R6 equal ff");
    flush();
  endtask

  task automatic t_extreme();
    step(1'b1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0, "R7 zero-vs-ff");
    step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'd0, "R7 ff-vs-zero");
    step(1'b1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 16'd100, "R7 max plus acc");
    flush();
  endtask

  task automatic t_wrap();
    step(1'b1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, "R8 wrap");
    step(1'b1, 64'h0000_0000_0000_0002, 64'h0, 16'hFFFF, "R8 wrap small");
    flush();
  endtask

  task automatic t_lanes();
    for (int i = 0; i < 8; i++) begin
      logic [63:0] a;
      a = 64'h8080_8080_8080_8080;
      a[i*8 +: 8] = 8'(8'h80 + 8'(i + 1) * 8'd3);
      step(1'b1, a, 64'h8080_8080_8080_8080, 16'd0, "R1 lane");
      step(1'b1, 64'h8080_8080_8080_8080, a, 16'd7, "R1 lane swap");
    end
    flush();
  endtask

  task automatic t_stream(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      logic [63:0] a, b;
      logic        v;
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      v = gaps ? (($urandom() % 3) != 0) : 1'b1;
      step(v, a, b, 16'($urandom()), gaps ? "R5 gapped" : "R4 back-to-back R2");
    end
    flush();
  endtask

  initial begin
    #(5ns * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd17));
    t_reset();
    t_equal();
    t_extreme();
    t_wrap();
    t_lanes();
    t_stream(200, 1'b0);
    t_stream(200, 1'b1);
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule